// File: doc/BRIEF.md
# Address-Area Bus Controller with Wait States

This block sits between four bus masters and an external memory bus. The masters are a processor, a descriptor-driven transfer engine, a DMA engine and an external master. Each master raises a request with its own 24-bit address and direction. The block picks one owner with a fixed priority and holds the grant for the whole access. It decodes the owner's address into one of eight 2 MB areas and drives a one-hot area select together with the latched address.

Every area has its own settings:

- a 2-bit wait count, which stretches the access to `waits + 1` cycles;
- a width bit, which marks the area as a 16-bit or an 8-bit port;
- for the four middle areas only, a flag that turns the area into a DRAM window.

When an access goes to a DRAM window, the block produces an active-low row strobe and column strobe. A one-cycle ready pulse marks the last cycle of every access. At least one idle cycle separates two accesses, and that idle cycle is where ownership may move to another master.

Top module: `area_bus_ctrl`

## Requirements
- R1: While reset is held and directly after it, `gnt_o` and `cs_o` are all zero, `ready_o` is 0, and `ras_n_o` and `cas_n_o` are 1.
- R2: During an access, `cs_o` has exactly the bit set whose index is address bits [23:21] of the owner. `bus_addr_o` and `bus_we_o` equal the owner's address and direction as they were sampled when the access started.
- R3: An access to area `a` lasts `w + 1` cycles, where `w = cfg_wait_i[2a+1:2a]`. `ready_o` is 1 only in the last cycle of the access.
- R4: When several requests are sampled in an idle cycle, the grant goes to the highest request index. Index 3 is the external master, 2 is DMA, 1 is the transfer engine and 0 is the CPU. `gnt_o` bit `m` marks master `m` as owner.
- R5: `gnt_o` is at most one-hot. It stays unchanged for the whole access, even if a higher-priority request arrives in the middle of it.
- R6: During an access, `bus_wide_o` equals `cfg_wide_i[a]` for the accessed area `a`, where 1 means a 16-bit port and 0 an 8-bit port.
- R7: For an access to area `a` with `a` in 2..5 and `cfg_dram_i[a-2] = 1`:
  - `ras_n_o` is 0 in every cycle of the access;
  - `cas_n_o` is 1 in the first cycle and 0 in every later cycle;
  - a wait count of 0 is raised to 1, so the access lasts 2 cycles.
- R8: Any access to an area that is not flagged as DRAM keeps `ras_n_o` and `cas_n_o` at 1. This includes areas 0, 1, 6 and 7, and areas 2..5 when their flag bit is 0.
- R9: In the cycle after `ready_o`, `gnt_o` and `cs_o` are zero.
- R10: Wait count, width and DRAM flag are sampled when the access starts. Changing `cfg_wait_i` during an access does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Per-master request (3 ext, 2 DMA, 1 transfer engine, 0 CPU) |
| addr_i | input | 96 | Per-master 24-bit address, master m in bits [24m+23:24m] |
| we_i | input | 4 | Per-master write flag |
| cfg_wait_i | input | 16 | Wait count per area, area a in bits [2a+1:2a] |
| cfg_wide_i | input | 8 | Per-area 16-bit port flag |
| cfg_dram_i | input | 4 | DRAM flag for areas 2..5, bit k for area k+2 |
| gnt_o | output | 4 | One-hot owner during an access |
| cs_o | output | 8 | One-hot area select during an access |
| bus_addr_o | output | 24 | Latched access address |
| bus_we_o | output | 1 | Latched write flag |
| bus_wide_o | output | 1 | Area port is 16 bits wide |
| ready_o | output | 1 | Pulse on the last access cycle |
| ras_n_o | output | 1 | Active-low row strobe |
| cas_n_o | output | 1 | Active-low column strobe |

## Verification
The assertions take for granted that reset is applied synchronously before any request, and that a master with a pending request keeps its address and direction stable in the idle cycle in which it may be granted. The bench changes requests and configuration only at falling edges. It keeps each master's address constant across the cycle in which that master is sampled. The bench also changes requests and wait settings in the middle of an access on purpose: these inputs may legally change at any time, and the grant, strobe and length checks must still hold.

// File: rtl/abc_pkg.sv
package abc_pkg;
    localparam int MASTER_CPU  = 0;
    localparam int MASTER_XFER = 1;
    localparam int MASTER_DMA  = 2;
    localparam int MASTER_EXT  = 3;
endpackage

// File: rtl/abc_area_decode.sv
module abc_area_decode #(
    parameter int ADDR_W     = 24,
    parameter int AREA_BITS  = 3,
    parameter int WAIT_W     = 2,
    parameter int DRAM_FIRST = 2,
    parameter int DRAM_AREAS = 4
) (
    input  logic [ADDR_W-1:0]                    addr_i,
    input  logic [(1<<AREA_BITS)*WAIT_W-1:0]     cfg_wait_i,
    input  logic [(1<<AREA_BITS)-1:0]            cfg_wide_i,
    input  logic [DRAM_AREAS-1:0]                cfg_dram_i,
    output logic [AREA_BITS-1:0]                 area_o,
    output logic [WAIT_W-1:0]                    waits_o,
    output logic                                 wide_o,
    output logic                                 dram_o
);
    localparam int NUM_AREAS = 1 << AREA_BITS;

    logic [NUM_AREAS-1:0] is_dram;

    for (genvar i = 0; i < NUM_AREAS; i++) begin : g_area
        if (i >= DRAM_FIRST && i < DRAM_FIRST + DRAM_AREAS) begin : g_dram
            assign is_dram[i] = cfg_dram_i[i-DRAM_FIRST];
        end else begin : g_sram
            assign is_dram[i] = 1'b0;
        end
    end

    always_comb begin
        area_o  = addr_i[ADDR_W-1 -: AREA_BITS];
        waits_o = cfg_wait_i[area_o*WAIT_W +: WAIT_W];
        wide_o  = cfg_wide_i[area_o];
        dram_o  = is_dram[area_o];
    end
endmodule

// File: rtl/abc_prio_arb.sv
module abc_prio_arb #(
    parameter int NUM_MASTERS = 4,
    parameter int MIDX_W      = 2
) (
    input  logic [NUM_MASTERS-1:0] req_i,
    output logic                   any_o,
    output logic [MIDX_W-1:0]      idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req_i[i]) idx_o = MIDX_W'(i);
        end
    end
endmodule

// File: rtl/abc_access_seq.sv
module abc_access_seq #(
    parameter int ADDR_W    = 24,
    parameter int AREA_BITS = 3,
    parameter int WAIT_W    = 2,
    parameter int MIDX_W    = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [MIDX_W-1:0]    owner_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [AREA_BITS-1:0] area_i,
    input  logic [WAIT_W-1:0]    waits_i,
    input  logic                 wide_i,
    input  logic                 dram_i,
    output logic                 busy_o,
    output logic [MIDX_W-1:0]    owner_o,
    output logic [ADDR_W-1:0]    addr_o,
    output logic                 we_o,
    output logic [AREA_BITS-1:0] area_o,
    output logic                 wide_o,
    output logic                 dram_o,
    output logic                 first_o,
    output logic                 last_o
);
    typedef struct packed {
        logic                 busy;
        logic [MIDX_W-1:0]    owner;
        logic [ADDR_W-1:0]    addr;
        logic                 we;
        logic [AREA_BITS-1:0] area;
        logic                 wide;
        logic                 dram;
        logic                 first;
        logic [WAIT_W-1:0]    cnt;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.owner = owner_i;
                st_d.addr  = addr_i;
                st_d.we    = we_i;
                st_d.area  = area_i;
                st_d.wide  = wide_i;
                st_d.dram  = dram_i;
                st_d.first = 1'b1;
                st_d.cnt   = (dram_i && waits_i == '0) ? WAIT_W'(1) : waits_i;
            end
        end else begin
            st_d.first = 1'b0;
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - WAIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = st_q.busy;
    assign owner_o = st_q.owner;
    assign addr_o  = st_q.addr;
    assign we_o    = st_q.we;
    assign area_o  = st_q.area;
    assign wide_o  = st_q.wide;
    assign dram_o  = st_q.dram;
    assign first_o = st_q.first;
    assign last_o  = st_q.busy && (st_q.cnt == '0);
endmodule

// File: rtl/area_bus_ctrl.sv
module area_bus_ctrl #(
    parameter int ADDR_W      = 24,
    parameter int AREA_BITS   = 3,
    parameter int WAIT_W      = 2,
    parameter int NUM_MASTERS = 4,
    parameter int DRAM_FIRST  = 2,
    parameter int DRAM_AREAS  = 4
) (
    input  logic                                clk_i,
    input  logic                                rst_ni,
    input  logic [NUM_MASTERS-1:0]              req_i,
    input  logic [NUM_MASTERS*ADDR_W-1:0]       addr_i,
    input  logic [NUM_MASTERS-1:0]              we_i,
    input  logic [(1<<AREA_BITS)*WAIT_W-1:0]    cfg_wait_i,
    input  logic [(1<<AREA_BITS)-1:0]           cfg_wide_i,
    input  logic [DRAM_AREAS-1:0]               cfg_dram_i,
    output logic [NUM_MASTERS-1:0]              gnt_o,
    output logic [(1<<AREA_BITS)-1:0]           cs_o,
    output logic [ADDR_W-1:0]                   bus_addr_o,
    output logic                                bus_we_o,
    output logic                                bus_wide_o,
    output logic                                ready_o,
    output logic                                ras_n_o,
    output logic                                cas_n_o
);
    localparam int NUM_AREAS = 1 << AREA_BITS;
    localparam int MIDX_W    = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    logic                 req_any;
    logic [MIDX_W-1:0]    req_idx;
    logic [ADDR_W-1:0]    sel_addr;
    logic                 sel_we;
    logic [AREA_BITS-1:0] dec_area;
    logic [WAIT_W-1:0]    dec_waits;
    logic                 dec_wide;
    logic                 dec_dram;

    logic                 busy;
    logic [MIDX_W-1:0]    owner_q;
    logic [AREA_BITS-1:0] area_q;
    logic                 wide_q;
    logic                 dram_q;
    logic                 first_q;

    abc_prio_arb #(
        .NUM_MASTERS(NUM_MASTERS),
        .MIDX_W     (MIDX_W)
    ) u_arb (
        .req_i(req_i),
        .any_o(req_any),
        .idx_o(req_idx)
    );

    always_comb begin
        sel_addr = addr_i[req_idx*ADDR_W +: ADDR_W];
        sel_we   = we_i[req_idx];
    end

    abc_area_decode #(
        .ADDR_W    (ADDR_W),
        .AREA_BITS (AREA_BITS),
        .WAIT_W    (WAIT_W),
        .DRAM_FIRST(DRAM_FIRST),
        .DRAM_AREAS(DRAM_AREAS)
    ) u_dec (
        .addr_i    (sel_addr),
        .cfg_wait_i(cfg_wait_i),
        .cfg_wide_i(cfg_wide_i),
        .cfg_dram_i(cfg_dram_i),
        .area_o    (dec_area),
        .waits_o   (dec_waits),
        .wide_o    (dec_wide),
        .dram_o    (dec_dram)
    );

    abc_access_seq #(
        .ADDR_W   (ADDR_W),
        .AREA_BITS(AREA_BITS),
        .WAIT_W   (WAIT_W),
        .MIDX_W   (MIDX_W)
    ) u_seq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .start_i(req_any),
        .owner_i(req_idx),
        .addr_i (sel_addr),
        .we_i   (sel_we),
        .area_i (dec_area),
        .waits_i(dec_waits),
        .wide_i (dec_wide),
        .dram_i (dec_dram),
        .busy_o (busy),
        .owner_o(owner_q),
        .addr_o (bus_addr_o),
        .we_o   (bus_we_o),
        .area_o (area_q),
        .wide_o (wide_q),
        .dram_o (dram_q),
        .first_o(first_q),
        .last_o (ready_o)
    );

    for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_gnt
        assign gnt_o[m] = busy && (owner_q == MIDX_W'(m));
    end

    for (genvar a = 0; a < NUM_AREAS; a++) begin : g_cs
        assign cs_o[a] = busy && (area_q == AREA_BITS'(a));
    end

    assign bus_wide_o = busy && wide_q;
    assign ras_n_o    = !(busy && dram_q);
    assign cas_n_o    = !(busy && dram_q && !first_q);
endmodule

// File: rtl/abc_checker.sv
module abc_checker #(
    parameter int NUM_MASTERS = 4,
    parameter int NUM_AREAS   = 8
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic [NUM_MASTERS-1:0] gnt_o,
    input logic [NUM_AREAS-1:0]   cs_o,
    input logic                   ready_o,
    input logic                   ras_n_o,
    input logic                   cas_n_o
);
    assert_gnt_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    assert_gnt_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o != '0 && !ready_o) |=> ($stable(gnt_o) && gnt_o != '0));

    assert_cs_with_gnt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cs_o) && ((cs_o != '0) == (gnt_o != '0)));

    assert_ready_in_access_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (gnt_o != '0));

    assert_idle_after_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> (gnt_o == '0 && cs_o == '0));

    assert_cas_inside_ras_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cas_n_o |-> !ras_n_o);

    assert_row_before_col_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ras_n_o) |-> cas_n_o);

    assert_strobes_middle_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ras_n_o |-> (|cs_o[5:2]));
endmodule

bind area_bus_ctrl abc_checker u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gnt_o  (gnt_o),
    .cs_o   (cs_o),
    .ready_o(ready_o),
    .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o)
);

// File: tb/tb_area_bus_ctrl.sv
`timescale 1ns/1ps
module tb_area_bus_ctrl;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  req_i = '0;
    logic [95:0] addr_i = '0;
    logic [3:0]  we_i = '0;
    logic [15:0] cfg_wait_i = '0;
    logic [7:0]  cfg_wide_i = '0;
    logic [3:0]  cfg_dram_i = '0;
    logic [3:0]  gnt_o;
    logic [7:0]  cs_o;
    logic [23:0] bus_addr_o;
    logic        bus_we_o, bus_wide_o, ready_o, ras_n_o, cas_n_o;

    int tests = 0;
    int fails = 0;

    int          c_cycles, c_ras_low, c_cas_low, c_ready_cnt;
    logic [3:0]  c_gnt, c_idle_gnt;
    logic [7:0]  c_cs, c_idle_cs;
    logic [23:0] c_addr;
    logic        c_we, c_wide, c_gnt_stable, c_first_cas_n;
    logic [3:0]  mid_req = '0;
    logic        mid_cfg = 1'b0;
    logic [15:0] mid_wait = '0;

    area_bus_ctrl dut (.*);

    always #2.5 clk_i = ~clk_i;

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_access(input logic [3:0] req);
        @(negedge clk_i);
        req_i = req;
        @(negedge clk_i);
        c_cycles = 0; c_ras_low = 0; c_cas_low = 0; c_ready_cnt = 0;
        c_gnt = gnt_o; c_cs = cs_o; c_addr = bus_addr_o; c_we = bus_we_o;
        c_wide = bus_wide_o; c_gnt_stable = 1'b1; c_first_cas_n = cas_n_o;
        for (int n = 0; n < 20; n++) begin
            c_cycles++;
            if (!ras_n_o) c_ras_low++;
            if (!cas_n_o) c_cas_low++;
            if (gnt_o != c_gnt) c_gnt_stable = 1'b0;
            if (n == 0) begin
                req_i = req_i | mid_req;
                if (mid_cfg) cfg_wait_i = mid_wait;
            end
            if (ready_o) break;
            @(negedge clk_i);
        end
        req_i = '0;
        @(negedge clk_i);
        c_idle_gnt = gnt_o;
        c_idle_cs = cs_o;
    endtask

    function automatic logic [23:0] mk_addr(input int area, input logic [20:0] off);
        return {area[2:0], off};
    endfunction

    task automatic t_reset();
        check(gnt_o == 0 && cs_o == 0, "R1 gnt/cs idle at reset", {gnt_o, cs_o}, 0);
        check(ready_o == 0 && ras_n_o && cas_n_o, "R1 ready/strobes at reset",
              {ready_o, ras_n_o, cas_n_o}, 3'b011);
    endtask

    task automatic t_area_decode();
        cfg_wait_i = '0; cfg_dram_i = '0;
        for (int a = 0; a < 8; a++) begin
            addr_i[23:0] = mk_addr(a, 21'h0ABCD + 21'(a));
            we_i[0] = a[0];
            run_access(4'b0001);
            check(c_cs == 8'(1 << a), "R2 area select", c_cs, 8'(1 << a));
            check(c_addr == mk_addr(a, 21'h0ABCD + 21'(a)) && c_we == a[0],
                  "R2 latched address/dir", {c_we, c_addr}, {a[0], mk_addr(a, 21'h0ABCD + 21'(a))});
        end
    endtask

    task automatic t_waits();
        cfg_dram_i = '0;
        cfg_wait_i = 16'b11_10_01_00_00_01_10_11;
        for (int a = 0; a < 8; a++) begin
            int w;
            w = (cfg_wait_i >> (2 * a)) & 3;
            addr_i[23:0] = mk_addr(a, 21'h100);
            run_access(4'b0001);
            check(c_cycles == w + 1, "R3 access length", c_cycles, w + 1);
        end
    endtask

    task automatic t_priority();
        logic [3:0] pats [6] = '{4'b1111, 4'b0111, 4'b0011, 4'b0001, 4'b1001, 4'b0101};
        logic [3:0] exps [6] = '{4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1000, 4'b0100};
        cfg_wait_i = '0; cfg_dram_i = '0;
        addr_i = '0;
        for (int i = 0; i < 6; i++) begin
            run_access(pats[i]);
            check(c_gnt == exps[i], "R4 fixed priority grant", c_gnt, exps[i]);
        end
    endtask

    task automatic t_hold();
        cfg_wait_i = 16'h0003;
        addr_i = '0;
        mid_req = 4'b1000;
        run_access(4'b0001);
        mid_req = '0;
        check(c_gnt == 4'b0001 && c_gnt_stable, "R5 grant held through access", c_gnt, 4'b0001);
        check(c_cycles == 4, "R5 owner access not cut", c_cycles, 4);
        check(c_idle_gnt == 0 && c_idle_cs == 0, "R9 idle cycle after ready", {c_idle_gnt, c_idle_cs}, 0);
    endtask

    task automatic t_width();
        cfg_wait_i = '0; cfg_dram_i = '0;
        cfg_wide_i = 8'b1010_0101;
        for (int a = 0; a < 8; a++) begin
            addr_i[71:48] = mk_addr(a, 21'h2);
            run_access(4'b0100);
            check(c_wide == cfg_wide_i[a], "R6 port width", c_wide, cfg_wide_i[a]);
        end
    endtask

    task automatic t_dram();
        cfg_dram_i = 4'b1111;
        cfg_wait_i = '0;
        cfg_wait_i[7:6] = 2'd2;
        addr_i[47:24] = mk_addr(3, 21'h40);
        run_access(4'b0010);
        check(c_cycles == 3 && c_ras_low == 3, "R7 row strobe whole access", {c_cycles, c_ras_low}, {32'd3, 32'd3});
        check(c_cas_low == 2 && c_first_cas_n, "R7 column strobe from second cycle", c_cas_low, 2);
        addr_i[47:24] = mk_addr(4, 21'h40);
        run_access(4'b0010);
        check(c_cycles == 2, "R7 zero wait raised to one", c_cycles, 2);
        check(c_ras_low == 2 && c_cas_low == 1, "R7 strobes at forced wait", {c_ras_low, c_cas_low}, {32'd2, 32'd1});
    endtask

    task automatic t_nodram();
        cfg_dram_i = 4'b0010;
        cfg_wait_i = '0;
        for (int a = 0; a < 8; a++) begin
            addr_i[23:0] = mk_addr(a, 21'h7);
            run_access(4'b0001);
            if (a == 3) check(c_ras_low == 2, "R8 flagged area strobes", c_ras_low, 2);
            else check(c_ras_low == 0 && c_cas_low == 0, "R8 no strobes outside flagged area",
                       {c_ras_low, c_cas_low}, 0);
        end
        cfg_dram_i = '0;
    endtask

    task automatic t_cfg_mid();
        cfg_wait_i = 16'b00_00_00_00_00_00_01_00;
        addr_i[23:0] = mk_addr(1, 21'h9);
        mid_cfg = 1'b1;
        mid_wait = 16'b00_00_00_00_00_00_11_00;
        run_access(4'b0001);
        mid_cfg = 1'b0;
        check(c_cycles == 2, "R10 settings sampled at start", c_cycles, 2);
        run_access(4'b0001);
        check(c_cycles == 4, "R10 new setting on next access", c_cycles, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_area_decode();
        t_waits();
        t_priority();
        t_hold();
        t_width();
        t_dram();
        t_nodram();
        t_cfg_mid();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule